// File: doc/BRIEF.md
# Chained Descriptor Table DMA Writer

This block moves a stream of 32-bit capture words into host memory. Host memory is organised as a ring of table pages. Each table page starts with the page number of the table that follows it, and the words after it name the buffer pages to fill. All references are 32-bit page numbers of 4 KiB pages. The block reads each table through a one-outstanding read port. It fills the named buffers one after another in table order, and it writes every buffer's last word after all the others. Software treats a nonzero last word as the sign that the buffer is complete.

Software loads the page number of the first table, then issues command words to the command register. These commands start or stop the walk, clear the table credit count or add one credit. The block enters a table only when a credit is available, and entering a table uses one credit. While no buffer page is ready, the block drops incoming capture words. It drops them when it is out of credit and also while it is fetching a table, and it raises a sticky overflow flag. The `cap_ready` output shows on each cycle whether a word offered on that cycle would be stored.

Top module: `chain_dma_writer`

## Requirements
- R1: After reset the block is stopped: `cap_ready`, `overflow`, `mem_rd_req` and `mem_wr_en` are all 0.
- R2: A write to register address 5 loads the first-table page number. A write to register address 0 is acted on only for the exact values 0x0C000040 (start), 0x08080000 (stop), 0x00000010 (clear credits) and 0x00000020 (add one credit). Any other value, and any write to another address, changes nothing.
- R3: On entering a table with page number P, the block reads byte address P*4096 (the next-table word). It then reads the buffer page numbers at P*4096+4*i for i = 1 to BUFS_PER_TABLE, in order. At most one read is outstanding at any time.
- R4: The k-th word accepted into a buffer with page number Q is written unchanged to byte address Q*4096+4*k, one cycle after it is accepted. Buffers are filled in table order, so word WORDS_PER_BUF-1 of a buffer is the last one written to it.
- R5: After the last word of the last buffer of a table, the block moves on to the table named by that table's word 0. Because the chain is a ring, the walk wraps back to the first table.
- R6: The block enters a table only while the credit count is above zero, and entering a table takes one credit. The clear command sets the count to 0. The add command raises it by one and saturates at the maximum.
- R7: While the block is started, a capture word offered with `cap_ready` low is not written and sets `overflow`. `overflow` stays set until the next start command. Words offered while the block is stopped are ignored and do not set `overflow`.
- R8: The stop command returns the block to the stopped state with `cap_ready` low and issues no further writes. A start command restarts the walk at the table held in the first-table register.
- R9: `cap_ready` is high exactly on the cycles in which an offered capture word is accepted and written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (0 command, 5 first table) |
| reg_wdata | input | 32 | Register write data |
| cap_valid | input | 1 | Capture word present |
| cap_data | input | 32 | Capture word |
| cap_ready | output | 1 | An offered word is stored this cycle |
| overflow | output | 1 | Sticky flag: a word was dropped while started |
| mem_rd_req | output | 1 | Table read request (one-cycle pulse) |
| mem_rd_addr | output | 44 | Table read byte address |
| mem_rd_valid | input | 1 | Read response present |
| mem_rd_data | input | 32 | Read response word |
| mem_wr_en | output | 1 | Buffer word write |
| mem_wr_addr | output | 44 | Buffer write byte address |
| mem_wr_data | output | 32 | Buffer write data |

## Verification
The bench builds the block with 4 words per buffer, 3 buffers per table and a 4-bit credit counter, and walks a ring of 3 tables. At this size every buffer switch, every table switch and the wrap back to the first table occur many times within a few hundred cycles. The bench checks every read and write address against values it computes arithmetically from a running word count. The short table also makes credit exhaustion, credit clearing and restart at a different first table cheap to reach. Those cases are checked together with dropped words while starved and while stopped.

// File: rtl/chain_dma_writer.sv
module chain_dma_writer #(
  parameter int DW             = 32,
  parameter int PFN_W          = 32,
  parameter int PAGE_SHIFT     = 12,
  parameter int WORDS_PER_BUF  = 1024,
  parameter int BUFS_PER_TABLE = 511,
  parameter int CREDIT_W       = 8,
  parameter int AW             = PFN_W + PAGE_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          cap_valid,
  input  logic [DW-1:0] cap_data,
  output logic          cap_ready,
  output logic          overflow,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data
);
  localparam int WCW = $clog2(WORDS_PER_BUF);
  localparam int BCW = $clog2(BUFS_PER_TABLE + 1);
  localparam logic [2:0] REG_CMD = 3'd0;
  localparam logic [2:0] REG_FIRST = 3'd5;
  localparam logic [DW-1:0] CMD_START = DW'(32'h0C00_0040);
  localparam logic [DW-1:0] CMD_STOP  = DW'(32'h0808_0000);
  localparam logic [DW-1:0] CMD_CLR   = DW'(32'h0000_0010);
  localparam logic [DW-1:0] CMD_ADD   = DW'(32'h0000_0020);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HDR, S_FILL} state_t;

  state_t               state;
  logic [PFN_W-1:0]     first_pfn, cur_tbl, next_tbl, cur_buf, nxt_buf;
  logic                 buf_ok, nxt_ok, rd_busy, rd_drop;
  logic [WCW-1:0]       word_idx;
  logic [BCW-1:0]       buf_idx, pf_idx;
  logic [CREDIT_W-1:0]  credit;

  wire cmd_we    = reg_we && reg_addr == REG_CMD;
  wire do_start  = cmd_we && reg_wdata == CMD_START;
  wire do_stop   = cmd_we && reg_wdata == CMD_STOP;
  wire do_clr    = cmd_we && reg_wdata == CMD_CLR;
  wire do_add    = cmd_we && reg_wdata == CMD_ADD;
  wire ctl       = do_start || do_stop;
  wire rsp       = mem_rd_valid && !rd_drop;
  wire take      = cap_valid && cap_ready;
  wire last_word = word_idx == WCW'(WORDS_PER_BUF - 1);
  wire last_buf  = buf_idx == BCW'(BUFS_PER_TABLE - 1);
  wire consume   = state == S_WAIT && credit != '0 && !rd_busy && !ctl;
  wire prefetch  = state == S_FILL && !rd_busy && !nxt_ok &&
                   pf_idx < BCW'(BUFS_PER_TABLE) && !ctl;

  assign cap_ready = state == S_FILL && buf_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) credit <= '0;
    else if (do_clr) credit <= '0;
    else if (do_add && !consume) begin
      if (credit != '1) credit <= credit + 1'b1;
    end else if (consume && !do_add) credit <= credit - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) first_pfn <= '0;
    else if (reg_we && reg_addr == REG_FIRST) first_pfn <= reg_wdata[PFN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      rd_busy     <= 1'b0;
      rd_drop     <= 1'b0;
    end else begin
      mem_rd_req <= consume || prefetch;
      if (consume || prefetch)
        mem_rd_addr <= {cur_tbl, {PAGE_SHIFT{1'b0}}} |
                       ((consume ? AW'(0) : AW'(pf_idx) + AW'(1)) << 2);
      if (mem_rd_valid) begin
        rd_busy <= 1'b0;
        rd_drop <= 1'b0;
      end
      if (consume || prefetch) rd_busy <= 1'b1;
      if (ctl) rd_drop <= rd_busy && !mem_rd_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cur_tbl     <= '0;
      next_tbl    <= '0;
      cur_buf     <= '0;
      nxt_buf     <= '0;
      buf_ok      <= 1'b0;
      nxt_ok      <= 1'b0;
      word_idx    <= '0;
      buf_idx     <= '0;
      pf_idx      <= '0;
      overflow    <= 1'b0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      mem_wr_en <= take;
      if (take) begin
        mem_wr_addr <= {cur_buf, {PAGE_SHIFT{1'b0}}} | (AW'(word_idx) << 2);
        mem_wr_data <= cap_data;
      end
      if (cap_valid && !cap_ready && state != S_IDLE) overflow <= 1'b1;

      if (do_start) begin
        state    <= S_WAIT;
        cur_tbl  <= first_pfn;
        overflow <= 1'b0;
        buf_ok   <= 1'b0;
        nxt_ok   <= 1'b0;
      end else if (do_stop) begin
        state  <= S_IDLE;
        buf_ok <= 1'b0;
        nxt_ok <= 1'b0;
      end else begin
        case (state)
          S_WAIT: if (consume) state <= S_HDR;
          S_HDR: if (rsp) begin
            next_tbl <= mem_rd_data[PFN_W-1:0];
            state    <= S_FILL;
            pf_idx   <= '0;
            buf_idx  <= '0;
            word_idx <= '0;
          end
          S_FILL: begin
            if (rsp) begin
              nxt_buf <= mem_rd_data[PFN_W-1:0];
              nxt_ok  <= 1'b1;
            end
            if (prefetch) pf_idx <= pf_idx + 1'b1;
            if (take) begin
              word_idx <= last_word ? '0 : word_idx + 1'b1;
              if (last_word) begin
                if (last_buf) begin
                  state   <= S_WAIT;
                  cur_tbl <= next_tbl;
                  buf_ok  <= 1'b0;
                end else begin
                  buf_idx <= buf_idx + 1'b1;
                  buf_ok  <= nxt_ok;
                  if (nxt_ok) begin
                    cur_buf <= nxt_buf;
                    nxt_ok  <= 1'b0;
                  end
                end
              end
            end else if (!buf_ok && nxt_ok) begin
              cur_buf <= nxt_buf;
              buf_ok  <= 1'b1;
              nxt_ok  <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/chain_dma_writer_chk.sv
module chain_dma_writer_chk #(
  parameter int PAGE_SHIFT    = 12,
  parameter int WORDS_PER_BUF = 1024,
  parameter int CREDIT_W      = 8,
  parameter int AW            = 44
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic [2:0]          reg_addr,
  input logic                cap_valid,
  input logic                cap_ready,
  input logic                overflow,
  input logic                mem_rd_req,
  input logic                mem_wr_en,
  input logic [AW-1:0]       mem_wr_addr,
  input logic [1:0]          state,
  input logic [CREDIT_W-1:0] credit
);
  assert_wr_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(cap_valid && cap_ready));

  assert_wr_inside_buffer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> int'(mem_wr_addr[PAGE_SHIFT-1:0]) < WORDS_PER_BUF * 4);

  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready && state != 2'd0 && !(reg_we && reg_addr == 3'd0))
    |=> overflow);

  assert_no_credit_no_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && credit == '0) |=> state != 2'd2);

  assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);
endmodule

bind chain_dma_writer chain_dma_writer_chk #(
  .PAGE_SHIFT(PAGE_SHIFT), .WORDS_PER_BUF(WORDS_PER_BUF),
  .CREDIT_W(CREDIT_W), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .cap_valid(cap_valid), .cap_ready(cap_ready), .overflow(overflow),
  .mem_rd_req(mem_rd_req), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
  .state(state), .credit(credit)
);

// File: tb/chain_dma_writer_tb.sv
module chain_dma_writer_tb;
  localparam int CLK_P = 10;
  localparam int W = 4;
  localparam int B = 3;
  localparam int T = 3;
  localparam int AW = 44;
  localparam logic [31:0] BASE = 32'hC000_0000;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic cap_valid = 0;
  logic [31:0] cap_data = 0;
  logic cap_ready, overflow, mem_rd_req, mem_wr_en;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic mem_rd_valid = 0;
  logic [31:0] mem_rd_data = 0;
  logic [31:0] mem_wr_data;

  int checks = 0, fails = 0;
  int seen = 0, sent = 0, rd_seq = 0, st_t = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  chain_dma_writer #(.WORDS_PER_BUF(W), .BUFS_PER_TABLE(B), .CREDIT_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cap_valid(cap_valid), .cap_data(cap_data),
    .cap_ready(cap_ready), .overflow(overflow), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data));

  function automatic logic [31:0] tblpfn(int t);
    return 32'h100 + t;
  endfunction
  function automatic logic [31:0] bufpfn(int t, int b);
    return 32'h2000 + 16 * t + b;
  endfunction
  function automatic logic [31:0] model(logic [AW-1:0] a);
    for (int t = 0; t < T; t++)
      if (a[AW-1:12] == tblpfn(t))
        return (a[11:2] == 0) ? tblpfn((t + 1) % T) : bufpfn(t, int'(a[11:2]) - 1);
    return 32'h0;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    mem_rd_valid <= mem_rd_req;
    mem_rd_data  <= model(mem_rd_addr);
  end

  always @(negedge clk) begin
    if (rst_n && mem_wr_en) begin
      int n, t, b, w;
      logic [AW-1:0] ea;
      n = seen;
      t = (st_t + n / (W * B)) % T;
      b = (n / W) % B;
      w = n % W;
      ea = {bufpfn(t, b), 12'h000} + AW'(w * 4);
      if (n >= W * B) chk(mem_wr_addr == ea, "R5", 64'(mem_wr_addr), 64'(ea));
      else chk(mem_wr_addr == ea, "R4", 64'(mem_wr_addr), 64'(ea));
      chk(mem_wr_data == BASE + n, "R4", 64'(mem_wr_data), 64'(BASE + n));
      seen++;
    end
    if (rst_n && mem_rd_req) begin
      int t, wd;
      logic [AW-1:0] ea;
      wd = rd_seq % (B + 1);
      t = (st_t + rd_seq / (B + 1)) % T;
      ea = {tblpfn(t), 12'h000} + AW'(wd * 4);
      chk(mem_rd_addr == ea, "R3", 64'(mem_rd_addr), 64'(ea));
      rd_seq++;
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic start_at(int t);
    wr(3'd5, tblpfn(t));
    st_t = t; seen = 0; sent = 0; rd_seq = 0;
    wr(3'd0, 32'h0C00_0040);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stream(int n, string req);
    int k = 0, guard = 0;
    while (k < n && guard < 2000) begin
      @(negedge clk);
      if (cap_ready) begin
        cap_valid = 1; cap_data = BASE + sent; sent++; k++;
      end else cap_valid = 0;
      guard++;
    end
    @(negedge clk);
    cap_valid = 0;
    chk(k == n, req, 64'(k), 64'(n));
  endtask

  task automatic offer_blind(int n);
    repeat (n) begin
      @(negedge clk);
      cap_valid = 1; cap_data = 32'hDEAD_0000;
    end
    @(negedge clk);
    cap_valid = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cap_ready == 0, "R1", 64'(cap_ready), 0);
    chk(overflow == 0, "R1", 64'(overflow), 0);
    chk(mem_rd_req == 0 && mem_wr_en == 0, "R1", 64'({mem_rd_req, mem_wr_en}), 0);
    rst_n = 1;
    idle(2);

    wr(3'd0, 32'h10);
    wr(3'd0, 32'h20);
    wr(3'd0, 32'h20);
    start_at(0);
    stream(2 * W * B, "R4");
    idle(12);
    chk(cap_ready == 0, "R6", 64'(cap_ready), 0);
    chk(seen == 2 * W * B, "R4", 64'(seen), 64'(2 * W * B));

    // R2 near-miss commands and wrong address do nothing
    wr(3'd0, 32'h21);
    wr(3'd1, 32'h20);
    wr(3'd3, 32'h0C00_0040);
    idle(12);
    chk(cap_ready == 0, "R2", 64'(cap_ready), 0);

    // R7 starved words dropped and flagged
    offer_blind(3);
    idle(2);
    chk(overflow == 1, "R7", 64'(overflow), 1);
    chk(seen == 2 * W * B, "R7", 64'(seen), 64'(2 * W * B));

    wr(3'd0, 32'h20);
    stream(W * B, "R6");
    idle(12);
    chk(cap_ready == 0, "R6", 64'(cap_ready), 0);
    wr(3'd0, 32'h20);
    stream(W, "R5");
    idle(3);
    chk(seen == 3 * W * B + W, "R5", 64'(seen), 64'(3 * W * B + W));

    // R8 stop
    wr(3'd0, 32'h0808_0000);
    idle(3);
    chk(cap_ready == 0, "R8", 64'(cap_ready), 0);
    offer_blind(2);
    idle(2);
    chk(seen == 3 * W * B + W, "R8", 64'(seen), 64'(3 * W * B + W));

    // R6 clear credits, restart elsewhere
    wr(3'd0, 32'h20);
    wr(3'd0, 32'h20);
    wr(3'd0, 32'h20);
    wr(3'd0, 32'h10);
    start_at(1);
    idle(1);
    chk(overflow == 0, "R7", 64'(overflow), 0);
    idle(12);
    chk(cap_ready == 0, "R6", 64'(cap_ready), 0);
    wr(3'd0, 32'h0808_0000);
    offer_blind(3);
    idle(2);
    chk(overflow == 0, "R7", 64'(overflow), 0);
    chk(mem_rd_req == 0, "R8", 64'(mem_rd_req), 0);

    wr(3'd0, 32'h20);
    wr(3'd0, 32'h20);
    start_at(1);
    stream(2 * W * B, "R9");
    idle(6);
    chk(seen == sent, "R9", 64'(seen), 64'(sent));
    chk(overflow == 0, "R9", 64'(overflow), 0);
    finish_up();
  end
endmodule